// File: doc/BRIEF.md
# I2C Event Interrupt and DMA Request Controller

This block collects the event flags of an I2C master peripheral and turns them into one level-sensitive interrupt line and two DMA request lines, one per data direction. The transfer and data-path logic raises events through one-cycle set pulses and drops the ready flags through hardware clear pulses. Software reaches the block through register read and write strobes with a small select code.

Software can read the status word and write ones to it to acknowledge events. It can program an interrupt-enable mask and a DMA configuration word. It can also force the low six events through a self-test write. A vector read returns the 1-based number of the lowest enabled pending event and acknowledges that event in the same access.

A parameter selects the older or the newer register behaviour. The older behaviour has a working vector port but no software status clearing. The newer behaviour has software status clearing and self-test forcing but no working vector port.

Top module: `i2c_event_irq`

## Requirements
- R1: After reset the status, enable mask and DMA configuration read as 0, and `irq`, `rx_dreq` and `tx_dreq` are low.
- R2: `irq` is high in the cycle after the one in which `status & mask` is nonzero, and low in the cycle after the one in which it is zero.
- R3: Writing the enable register (`reg_sel` = 1) stores `wdata & 0x3F` when `NEW_REV` = 1 and `wdata & 0x1F` when `NEW_REV` = 0.
- R4: Writing the DMA register (`reg_sel` = 3) stores only bits 15 (receive enable) and 7 (transmit enable). In the same write, bit 15 set clears enable-mask bit 3 and bit 7 set clears enable-mask bit 4.
- R5: `rx_dreq` equals the previous cycle's DMA bit 15 AND status bit 3 (receive ready). `tx_dreq` equals the previous cycle's DMA bit 7 AND status bit 4 (transmit ready).
- R6: A status read (`reg_sel` = 0) returns the stored status OR'ed with `bus_busy` in bit 12.
- R7: With `NEW_REV` = 0, a vector read (`reg_sel` = 2) returns the 1-based position of the lowest set bit of `status & mask`, or 0 when none is set. A nonzero result clears that status bit at the end of the access.
- R8: With `NEW_REV` = 1, a vector read returns 0 and leaves the status unchanged.
- R9: With `NEW_REV` = 1, a status write clears each status bit whose `wdata` bit is 1, limited to bits 0, 1, 2 and 5, so ready bits 3 and 4 are untouched. With `NEW_REV` = 0, a status write has no effect.
- R10: With `NEW_REV` = 1, a self-test write (`reg_sel` = 4) with `wdata` bit 11 set sets status bits 0 to 5. With `NEW_REV` = 0, it has no effect.
- R11: `evt_set` sets status bits and `evt_clr` clears them. A set pulse on a bit wins over any clear of that bit in the same cycle, whether the clear comes from `evt_clr`, a status write or a vector acknowledge.
- R12: Reads of select codes 4 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (vector acknowledge) |
| reg_sel | input | 3 | Register select: 0 status, 1 enable, 2 vector, 3 DMA, 4 self-test |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the current select, combinational |
| evt_set | input | 16 | Per-bit status set pulses from the transfer logic |
| evt_clr | input | 16 | Per-bit status clear pulses from the transfer logic |
| bus_busy | input | 1 | Bus busy indication, reported in status bit 12 |
| irq | output | 1 | Registered level interrupt |
| rx_dreq | output | 1 | Registered receive DMA request |
| tx_dreq | output | 1 | Registered transmit DMA request |

## Verification
A hardware set pulse and a software or hardware clear can hit the same status bit in the same cycle. The bench provokes this in three ways: it drives `evt_set` together with `evt_clr`, it drives `evt_set` during a status write that clears the same bit, and it drives `evt_set` during a vector read whose acknowledge targets that bit. In each case it reads the status back afterwards and expects the bit to remain set. A sweep over all 63 nonzero six-bit event patterns and three masks runs against an older-revision and a newer-revision instance side by side. For each case the expected vector, the residual status and the interrupt level are computed arithmetically in the bench.

// File: rtl/i2c_event_irq.sv
module i2c_event_irq #(
  parameter bit NEW_REV = 1'b1,
  parameter int SW      = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_sel,
  input  logic [SW-1:0] wdata,
  output logic [SW-1:0] rdata,
  input  logic [SW-1:0] evt_set,
  input  logic [SW-1:0] evt_clr,
  input  logic          bus_busy,
  output logic          irq,
  output logic          rx_dreq,
  output logic          tx_dreq
);
  localparam int        IW       = $clog2(SW + 1);
  localparam [SW-1:0]   EN_LEGAL = NEW_REV ? SW'(16'h003F) : SW'(16'h001F);
  localparam [SW-1:0]   SW_CLR   = SW'(16'h0027);
  localparam [SW-1:0]   FORCE    = SW'(16'h003F);
  localparam [SW-1:0]   DMA_KEEP = SW'(16'h8080);
  localparam [2:0] SEL_STAT = 3'd0, SEL_EN = 3'd1, SEL_VEC = 3'd2,
                   SEL_DMA = 3'd3, SEL_TEST = 3'd4;

  logic [SW-1:0] stat, mask, dcfg;
  logic [SW-1:0] vec_oh;
  logic [IW-1:0] vec_idx;

  wire [SW-1:0] pend = stat & mask;

  always_comb begin
    vec_idx = '0;
    vec_oh  = '0;
    for (int i = SW - 1; i >= 0; i--) begin
      if (pend[i]) begin
        vec_idx   = IW'(i + 1);
        vec_oh    = '0;
        vec_oh[i] = 1'b1;
      end
    end
  end

  wire vec_ack  = reg_rd && reg_sel == SEL_VEC && !NEW_REV;
  wire stat_wr  = reg_wr && reg_sel == SEL_STAT && NEW_REV;
  wire test_set = reg_wr && reg_sel == SEL_TEST && NEW_REV && wdata[11];
  wire en_wr    = reg_wr && reg_sel == SEL_EN;
  wire dma_wr   = reg_wr && reg_sel == SEL_DMA;

  wire [SW-1:0] clr_all = evt_clr | (stat_wr ? (wdata & SW_CLR) : '0)
                        | (vec_ack ? vec_oh : '0);
  wire [SW-1:0] set_all = evt_set | (test_set ? FORCE : '0);

  logic [SW-1:0] dma_mclr;
  always_comb begin
    dma_mclr    = '0;
    dma_mclr[3] = wdata[15];
    dma_mclr[4] = wdata[7];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat    <= '0;
      mask    <= '0;
      dcfg    <= '0;
      irq     <= 1'b0;
      rx_dreq <= 1'b0;
      tx_dreq <= 1'b0;
    end else begin
      stat    <= (stat & ~clr_all) | set_all;
      if (en_wr)       mask <= wdata & EN_LEGAL;
      else if (dma_wr) mask <= mask & ~dma_mclr;
      if (dma_wr)      dcfg <= wdata & DMA_KEEP;
      irq     <= |pend;
      rx_dreq <= dcfg[15] & stat[3];
      tx_dreq <= dcfg[7] & stat[4];
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_STAT: begin
        rdata     = stat;
        rdata[12] = stat[12] | bus_busy;
      end
      SEL_EN:  rdata = mask;
      SEL_VEC: rdata = NEW_REV ? '0 : SW'(vec_idx);
      SEL_DMA: rdata = dcfg;
      default: rdata = '0;
    endcase
  end

  // R2: interrupt level lags the pending vector by one cycle
  p_irq_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (irq == ($past(stat & mask) != '0)));

  // R4: a DMA write with receive enable drops the receive-ready enable
  p_dma_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == SEL_DMA && wdata[15]) |=> !mask[3]);

  // R5: a receive request needs ready and enable one cycle earlier
  p_rx_dreq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dreq |-> ($past(stat[3]) && $past(dcfg[15])));

  p_tx_dreq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dreq |-> ($past(stat[4]) && $past(dcfg[7])));

  // R7: the acknowledged bit is gone after a vector read unless re-set
  p_vec_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_sel == SEL_VEC && !NEW_REV && (vec_oh & evt_set) == '0)
    |=> (stat & $past(vec_oh)) == '0);

  // R11: set pulses always land
  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set != '0) |=> (stat & $past(evt_set)) == $past(evt_set));

  // R3: the enable mask never holds bits beyond the legal set
  p_mask_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_wr) |-> (mask & ~EN_LEGAL) == '0);
endmodule

// File: tb/i2c_event_irq_bench.sv
module i2c_event_irq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, bus_busy = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [15:0] wdata = '0, evt_set = '0, evt_clr = '0;
  logic [15:0] rd_n, rd_o, cap_n, cap_o;
  logic        irq_n, irq_o, rxn, txn, rxo, txo;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  i2c_event_irq #(.NEW_REV(1'b1)) u_i2c_event_irq (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .wdata(wdata), .rdata(rd_n), .evt_set(evt_set),
    .evt_clr(evt_clr), .bus_busy(bus_busy), .irq(irq_n),
    .rx_dreq(rxn), .tx_dreq(txn));

  i2c_event_irq #(.NEW_REV(1'b0)) u_old (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .wdata(wdata), .rdata(rd_o), .evt_set(evt_set),
    .evt_clr(evt_clr), .bus_busy(bus_busy), .irq(irq_o),
    .rx_dreq(rxo), .tx_dreq(txo));

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic op(input logic wr, input logic rd, input logic [2:0] sel,
                    input logic [15:0] d, input logic [15:0] s, input logic [15:0] c);
    @(negedge clk);
    reg_wr = wr; reg_rd = rd; reg_sel = sel; wdata = d; evt_set = s; evt_clr = c;
    #1;
    cap_n = rd_n; cap_o = rd_o;
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0; reg_sel = 3'd7; wdata = '0; evt_set = '0; evt_clr = '0;
  endtask

  function automatic logic [15:0] lowest(input logic [15:0] v);
    for (int i = 0; i < 16; i++) if (v[i]) return 16'(i + 1);
    return 16'd0;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] m_n, m_o, e_vec, e_st;
    logic [15:0] masks [3];
    masks[0] = 16'h003F; masks[1] = 16'h0015; masks[2] = 16'h002A;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    op(0, 0, 3'd0, 0, 0, 0); chk("R1 stat new", cap_n, 0); chk("R1 stat old", cap_o, 0);
    op(0, 0, 3'd1, 0, 0, 0); chk("R1 mask", cap_n | cap_o, 0);
    op(0, 0, 3'd3, 0, 0, 0); chk("R1 dma", cap_n | cap_o, 0);
    chk("R1 outputs", {10'd0, irq_n, irq_o, rxn, txn, rxo, txo}, 0);
    // R3 mask width
    op(1, 0, 3'd1, 16'hFFFF, 0, 0);
    op(0, 0, 3'd1, 0, 0, 0); chk("R3 new", cap_n, 16'h003F); chk("R3 old", cap_o, 16'h001F);
    // R6 busy bit
    bus_busy = 1'b1;
    op(0, 0, 3'd0, 0, 16'h0001, 0);
    op(0, 0, 3'd0, 0, 0, 0); chk("R6 busy", cap_n, 16'h1001);
    bus_busy = 1'b0;
    op(0, 0, 3'd0, 0, 0, 0); chk("R6 idle", cap_o, 16'h0001);
    // R12 unused selects
    for (int s = 4; s < 8; s++) begin
      op(0, 1, 3'(s), 0, 0, 0); chk("R12 unused", cap_n | cap_o, 0);
    end
    // R2, R7, R8 sweep
    for (int mi = 0; mi < 3; mi++) begin
      for (int p = 1; p < 64; p++) begin
        op(1, 0, 3'd1, masks[mi], 0, 16'hFFFF);
        op(0, 0, 3'd0, 0, 16'(p), 0);
        @(negedge clk);
        m_n = masks[mi] & 16'h3F; m_o = masks[mi] & 16'h1F;
        chk("R2 irq new", {15'd0, irq_n}, {15'd0, (16'(p) & m_n) != 0});
        chk("R2 irq old", {15'd0, irq_o}, {15'd0, (16'(p) & m_o) != 0});
        e_vec = lowest(16'(p) & m_o);
        op(0, 1, 3'd2, 0, 0, 0);
        chk("R7 vector", cap_o, e_vec);
        chk("R8 vector", cap_n, 0);
        e_st = (e_vec != 0) ? (16'(p) & ~(16'd1 << (e_vec - 1))) : 16'(p);
        op(0, 0, 3'd0, 0, 0, 0);
        chk("R7 residue", cap_o, e_st);
        chk("R8 residue", cap_n, 16'(p));
      end
    end
    // R9 status write clears
    op(1, 0, 3'd1, 0, 0, 16'hFFFF);
    op(0, 0, 3'd0, 0, 16'h003F, 0);
    op(1, 0, 3'd0, 16'hFFFF, 0, 0);
    op(0, 0, 3'd0, 0, 0, 0); chk("R9 new", cap_n, 16'h0018); chk("R9 old", cap_o, 16'h003F);
    // R10 self-test force
    op(0, 0, 3'd0, 0, 0, 16'hFFFF);
    op(1, 0, 3'd4, 16'h0800, 0, 0);
    op(0, 0, 3'd0, 0, 0, 0); chk("R10 new", cap_n, 16'h003F); chk("R10 old", cap_o, 0);
    op(0, 0, 3'd0, 0, 0, 16'hFFFF);
    op(1, 0, 3'd4, 16'h07FF, 0, 0);
    op(0, 0, 3'd0, 0, 0, 0); chk("R10 no bit11", cap_n, 0);
    // R4 DMA config and mask clearing
    op(1, 0, 3'd1, 16'h003F, 0, 0);
    op(1, 0, 3'd3, 16'hFFFF, 0, 0);
    op(0, 0, 3'd3, 0, 0, 0); chk("R4 dma new", cap_n, 16'h8080); chk("R4 dma old", cap_o, 16'h8080);
    op(0, 0, 3'd1, 0, 0, 0); chk("R4 mask new", cap_n, 16'h0027); chk("R4 mask old", cap_o, 16'h0007);
    op(1, 0, 3'd1, 16'h003F, 0, 0);
    op(1, 0, 3'd3, 16'h8000, 0, 0);
    op(0, 0, 3'd1, 0, 0, 0); chk("R4 rx only", cap_n, 16'h0037);
    // R5 DMA requests
    op(1, 0, 3'd3, 16'h8080, 0, 0);
    op(0, 0, 3'd0, 0, 16'h0008, 0);
    @(negedge clk);
    chk("R5 rx on", {14'd0, rxn, txn}, 16'h0002);
    op(0, 0, 3'd0, 0, 16'h0010, 16'h0008);
    @(negedge clk);
    chk("R5 tx on", {14'd0, rxo, txo}, 16'h0001);
    op(1, 0, 3'd3, 16'h0000, 0, 0);
    @(negedge clk);
    chk("R5 disabled", {14'd0, rxn, txn}, 0);
    // R11 set beats clear
    op(0, 0, 3'd0, 0, 0, 16'hFFFF);
    op(0, 0, 3'd0, 0, 16'h0001, 16'hFFFF);
    op(0, 0, 3'd0, 0, 0, 0); chk("R11 vs evt_clr", cap_n, 16'h0001);
    op(1, 0, 3'd0, 16'h0001, 16'h0001, 0);
    op(0, 0, 3'd0, 0, 0, 0); chk("R11 vs status write", cap_n, 16'h0001);
    op(1, 0, 3'd1, 16'h0001, 0, 0);
    op(0, 1, 3'd2, 0, 16'h0001, 0); chk("R11 vector value", cap_o, 16'h0001);
    op(0, 0, 3'd0, 0, 0, 0); chk("R11 vs vector ack", cap_o, 16'h0001);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule